// File: doc/BRIEF.md
# Serial Peripheral Port (Master/Slave Byte Shifter)

This block is a four-wire synchronous serial port that moves one byte per transfer. A small register window holds a control word, a status word and a byte buffer. As a master, the port makes the serial clock from the system clock at one of three rates, drives an active-low select line and shifts the buffer out while it shifts a reply byte in. As a slave, it follows a clock and select line supplied from outside, after synchronising them to the system clock.

Software sets the port up through the control word and then writes the buffer. In master mode that write starts the shift. In slave mode the write preloads the byte that goes out when the remote master clocks. When the byte has moved, the received value replaces the buffer contents and a sticky completion flag raises the interrupt line. A buffer write that arrives while a byte is still moving is discarded and, if the static check input is high, it sets a collision flag. The pads are represented only by output values and their output enables.

Top module: `spi_port`

## Requirements
- R1: After reset the control word, the status word and the interrupt are all zero, every output enable is low and the select output is high.
- R2: The control word uses bit 0 for enable, bits 2:1 for mode, bit 3 for bit order, bit 4 for clock idle level and bit 5 for select enable. In master mode (mode 0, 1 or 2), a buffer write (address 2) while enabled and idle starts an 8-bit shift. The clock rests at the idle level. Each leading edge (idle to active) samples the serial input, and each trailing edge presents the next output bit.
- R3: Mode 0, 1 and 2 give clock half periods of 1, 4 and 16 system cycles. The completion flag reads high exactly 18 half periods plus one cycle after the clock edge that accepted the buffer write.
- R4: Bit order 0 sends and receives the most significant bit first, and bit order 1 sends and receives the least significant bit first.
- R5: In master mode the select output is low from the start of the byte up to and including the last cycle of the byte. It returns high one full clock period after the last trailing edge. Its output enable follows the select-enable bit.
- R6: The status word uses bit 0 for the completion flag, bit 1 for the collision flag and bit 2 for busy. The completion flag drives the interrupt and is set together with copying the received byte into the buffer. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A new buffer write does not clear it.
- R7: A buffer write while a byte is moving does not disturb the transfer or the buffer. If the check input is high it sets the collision flag; if the check input is low the flag stays clear.
- R8: In slave mode (mode 3) the port samples on each leading edge of the external clock. After eight samples it completes and drives its output only while selected. When select enable is set, a high select input keeps the port idle; when select enable is clear, the select input is ignored.
- R9: Clearing the enable bit drops all three output enables at once, abandons a byte in flight and produces no completion.
- R10: The control word reads back as written, and the busy bit reads high while a master byte is moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 buffer |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid one cycle after the address |
| col_chk_en | input | 1 | Static enable for collision detection |
| irq | output | 1 | Interrupt request, equal to the completion flag |
| sclk_in | input | 1 | Serial clock from a remote master |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for the serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for serial data out |
| sel_n_in | input | 1 | Active-low select from a remote master |
| sel_n_out | output | 1 | Active-low select driven in master mode |
| sel_n_oe | output | 1 | Output enable for the select line |

## Verification
The master path is swept over all 256 transmit bytes with a reply byte derived from each, so that any stuck, swapped or dropped bit position shows up in either direction. Every combination of the three rates, both bit orders and both idle levels is then run with asymmetric byte values. These runs separate a reversed order from a correct one and a wrong sampling edge from a right one, and they pin the completion cycle to the exact half-period count. Mid-transfer buffer writes, with the collision check on and with it off, show that the transfer is unaffected and the flag behaves as specified. In slave mode, a bench-driven master clocks the port while selected, while deselected and with the select line ignored, which tells true select gating apart from free-running capture.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] MODE_SLAVE = 2'd3;

  typedef struct packed {
    logic       sel_en;
    logic       cpol;
    logic       lsb_first;
    logic [1:0] mode;
    logic       enable;
  } cfg_t;
endpackage

// File: rtl/spi_regs.sv
module spi_regs
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              col_chk_en,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] rx_byte,
  output cfg_t              cfg,
  output logic              load,
  output logic              done_flag,
  output logic              wcol_flag
);
  logic [DATA_W-1:0] buf_q;
  logic data_wr, stat_wr;

  assign data_wr = we && (addr == A_DATA);
  assign stat_wr = we && (addr == A_STAT);
  assign load    = data_wr && cfg.enable && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      buf_q     <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      rdata     <= '0;
    end else begin
      if (we && addr == A_CTRL) cfg <= cfg_t'(wdata[$bits(cfg_t)-1:0]);
      if (xfer_done) buf_q <= rx_byte;
      else if (data_wr && !busy) buf_q <= wdata;
      if (xfer_done) done_flag <= 1'b1;
      else if (stat_wr && !wdata[0]) done_flag <= 1'b0;
      if (data_wr && busy && col_chk_en) wcol_flag <= 1'b1;
      else if (stat_wr && !wdata[1]) wcol_flag <= 1'b0;
      case (addr)
        A_CTRL:  rdata <= DATA_W'(cfg);
        A_STAT:  rdata <= DATA_W'({busy, wcol_flag, done_flag});
        A_DATA:  rdata <= buf_q;
        default: rdata <= '0;
      endcase
    end
  end

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !(stat_wr && !wdata[0])) |=> done_flag);
  // R7
  wcol_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!col_chk_en && !wcol_flag) |=> !wcol_flag);
endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng #(
  parameter int DATA_W    = 8,
  parameter int DIV_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx,
  output logic              sclk,
  output logic              sdo,
  output logic              sel_n
);
  localparam int PH_LAST = 2 * DATA_W + 2;
  localparam int PH_W    = $clog2(PH_LAST + 1);
  localparam int CNT_W   = 2 * DIV_SHIFT;

  logic [CNT_W-1:0]  cnt, half_m1;
  logic [PH_W-1:0]   ph;
  logic [DATA_W-1:0] sr;

  always_comb begin
    case (mode)
      2'd0:    half_m1 = '0;
      2'd1:    half_m1 = CNT_W'((1 << DIV_SHIFT) - 1);
      default: half_m1 = '1;
    endcase
  end

  assign sdo = lsb_first ? sr[0] : sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; ph <= '0;
      sr <= '0; rx <= '0; sclk <= 1'b0; sel_n <= 1'b1;
    end else if (!en) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; ph <= '0;
      sclk <= cpol; sel_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        busy  <= 1'b1;
        sel_n <= 1'b0;
        cnt   <= half_m1;
        ph    <= '0;
        sr    <= load_data;
        sclk  <= cpol;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= half_m1;
          ph  <= ph + 1'b1;
          if (ph == PH_W'(PH_LAST - 1)) begin
            busy  <= 1'b0;
            sel_n <= 1'b1;
            done  <= 1'b1;
          end else if (ph < PH_W'(2 * DATA_W)) begin
            if (!ph[0]) begin
              sclk <= ~cpol;
              rx   <= lsb_first ? {sdi, rx[DATA_W-1:1]} : {rx[DATA_W-2:0], sdi};
            end else begin
              sclk <= cpol;
              sr   <= lsb_first ? (sr >> 1) : (sr << 1);
            end
          end
        end
      end else begin
        sclk <= cpol;
      end
    end
  end

  // R5
  sel_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sel_n);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic              sel_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sclk_in,
  input  logic              sel_n_in,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx,
  output logic              sdo,
  output logic              active
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              sclk_s, sel_s, sclk_prev, lead, trail;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic sck_q, sel_q;
      always_ff @(posedge clk) begin
        if (rst) begin sck_q <= 1'b0; sel_q <= 1'b1; end
        else begin sck_q <= sclk_in; sel_q <= sel_n_in; end
      end
      assign sclk_s = sck_q;
      assign sel_s  = sel_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sck_q, sel_q;
      always_ff @(posedge clk) begin
        if (rst) begin sck_q <= '0; sel_q <= '1; end
        else begin
          sck_q <= {sck_q[SYNC_STAGES-2:0], sclk_in};
          sel_q <= {sel_q[SYNC_STAGES-2:0], sel_n_in};
        end
      end
      assign sclk_s = sck_q[SYNC_STAGES-1];
      assign sel_s  = sel_q[SYNC_STAGES-1];
    end
  endgenerate

  assign active = !sel_en || !sel_s;
  assign lead   = active && (sclk_s != sclk_prev) && (sclk_s != cpol);
  assign trail  = active && (sclk_s != sclk_prev) && (sclk_s == cpol);
  assign busy   = (cnt != '0);
  assign sdo    = lsb_first ? sr[0] : sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0; cnt <= '0; done <= 1'b0; rx <= '0; sr <= '0;
    end else begin
      sclk_prev <= sclk_s;
      if (!en) begin
        cnt  <= '0;
        done <= 1'b0;
      end else begin
        done <= 1'b0;
        if (!active) begin
          cnt <= '0;
        end else if (lead) begin
          rx <= lsb_first ? {sdi, rx[DATA_W-1:1]} : {rx[DATA_W-2:0], sdi};
          if (cnt == CNT_W'(DATA_W - 1)) begin
            cnt  <= '0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (trail && busy) begin
          sr <= lsb_first ? (sr >> 1) : (sr << 1);
        end
        if (load && !busy) sr <= load_data;
      end
    end
  end

  // R8
  desel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_en && sel_s) |=> !done);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_SHIFT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              col_chk_en,
  output logic              irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sel_n_in,
  output logic              sel_n_out,
  output logic              sel_n_oe
);
  cfg_t              cfg;
  logic              load, done_flag, wcol_flag;
  logic              is_slave, m_en, s_en;
  logic              m_busy, m_done, m_sdo, s_busy, s_done, s_sdo, s_active;
  logic [DATA_W-1:0] m_rx, s_rx;

  assign is_slave = (cfg.mode == MODE_SLAVE);
  assign m_en     = cfg.enable && !is_slave;
  assign s_en     = cfg.enable && is_slave;

  spi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .col_chk_en(col_chk_en), .busy(m_busy || s_busy),
    .xfer_done(m_done || s_done), .rx_byte(is_slave ? s_rx : m_rx),
    .cfg(cfg), .load(load), .done_flag(done_flag), .wcol_flag(wcol_flag)
  );

  spi_master_eng #(.DATA_W(DATA_W), .DIV_SHIFT(DIV_SHIFT)) u_master (
    .clk(clk), .rst(rst), .en(m_en), .mode(cfg.mode), .lsb_first(cfg.lsb_first),
    .cpol(cfg.cpol), .load(load), .load_data(reg_wdata), .sdi(sdi),
    .busy(m_busy), .done(m_done), .rx(m_rx), .sclk(sclk_out), .sdo(m_sdo),
    .sel_n(sel_n_out)
  );

  spi_slave_eng #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
    .clk(clk), .rst(rst), .en(s_en), .lsb_first(cfg.lsb_first), .cpol(cfg.cpol),
    .sel_en(cfg.sel_en), .load(load), .load_data(reg_wdata), .sclk_in(sclk_in),
    .sel_n_in(sel_n_in), .sdi(sdi), .busy(s_busy), .done(s_done), .rx(s_rx),
    .sdo(s_sdo), .active(s_active)
  );

  assign irq      = done_flag;
  assign sdo      = is_slave ? s_sdo : m_sdo;
  assign sclk_oe  = m_en;
  assign sel_n_oe = m_en && cfg.sel_en;
  assign sdo_oe   = m_en || (s_en && s_active);

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg.enable |=> !(m_busy || s_busy));
  // R6
  irq_wcol_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && !(m_done || s_done)) |=> !irq);
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int CLK_P = 10;
  localparam logic [1:0] RA_CTRL = 2'd0, RA_STAT = 2'd1, RA_DATA = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic reg_we = 1'b0; logic [1:0] reg_addr = '0; logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata; logic col_chk_en = 1'b1; logic irq;
  logic sclk_in = 1'b0, sclk_out, sclk_oe, sdi, sdo, sdo_oe;
  logic sel_n_in = 1'b1, sel_n_out, sel_n_oe;
  logic s_mode = 1'b0, r_sdi = 1'b0, t_sdi = 1'b0;
  assign sdi = s_mode ? t_sdi : r_sdi;

  spi_port dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .col_chk_en(col_chk_en), .irq(irq), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .sel_n_in(sel_n_in), .sel_n_out(sel_n_out), .sel_n_oe(sel_n_oe)
  );

  int n_chk = 0, n_fail = 0;
  logic r_on = 1'b0, r_cpol = 1'b0, r_lsb = 1'b0, r_prev = 1'b0;
  logic [7:0] r_reply = '0, r_cap = '0;
  int r_idx = 0, r_selbad = 0;

  // remote device model for master-mode runs
  always @(negedge clk) begin
    if (r_on && sclk_out !== r_prev) begin
      if (sclk_out != r_cpol) begin
        r_cap = {r_cap[6:0], sdo};
        if (sel_n_out) r_selbad++;
      end else begin
        r_idx++;
        if (r_idx < 8) r_sdi = r_lsb ? r_reply[r_idx] : r_reply[7-r_idx];
      end
      r_prev = sclk_out;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic master_xfer(input logic [1:0] mode, input bit lsb, input bit cpol,
                             input logic [7:0] tx, input logic [7:0] reply,
                             input bit collide, input bit chk_en);
    int h;
    logic pre;
    logic [7:0] v;
    h = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 4 : 16;
    s_mode = 1'b0;
    col_chk_en = chk_en;
    wr(RA_CTRL, {2'b00, 1'b1, cpol, lsb, mode, 1'b1});
    r_sdi = lsb ? reply[0] : reply[7];
    r_lsb = lsb; r_cpol = cpol; r_reply = reply; r_idx = 0; r_cap = '0;
    r_prev = cpol; r_selbad = 0;
    pre = irq;
    wr(RA_DATA, tx);
    r_on = 1'b1;
    if (collide) begin
      repeat (5) @(negedge clk);
      wr(RA_DATA, 8'hFF);
      repeat (18*h - 7) @(negedge clk);
    end else begin
      repeat (18*h - 1) @(negedge clk);
    end
    chk(sel_n_out == 1'b0, "R5 select low in last cycle", sel_n_out, 0);
    @(negedge clk);
    chk(sel_n_out == 1'b1, "R5 select released", sel_n_out, 1);
    chk(irq == pre, "R6 flag not yet set / not cleared by buffer write", irq, pre);
    chk(sclk_out == cpol, "R2 clock back at idle level", sclk_out, cpol);
    @(negedge clk);
    chk(irq == 1'b1, "R3 completion at 18 half periods", irq, 1);
    r_on = 1'b0;
    chk(r_cap == (lsb ? rev8(tx) : tx), "R4 transmitted bit order", r_cap, lsb ? rev8(tx) : tx);
    chk(r_selbad == 0, "R5 select low at every leading edge", r_selbad, 0);
    rd(RA_DATA, v);
    chk(v == reply, "R2 received byte in buffer", v, reply);
  endtask

  task automatic slave_xfer(input bit lsb, input bit cpol, input bit sel_en, input bit sel_n,
                            input logic [7:0] tx, input logic [7:0] rxb, input bit expect_run);
    logic [7:0] cap, v;
    s_mode = 1'b1;
    sclk_in = cpol; sel_n_in = sel_n;
    wr(RA_STAT, 8'h00);
    wr(RA_CTRL, {2'b00, sel_en, cpol, lsb, 2'b11, 1'b1});
    wr(RA_DATA, tx);
    repeat (4) @(negedge clk);
    cap = '0;
    for (int i = 0; i < 8; i++) begin
      t_sdi = lsb ? rxb[i] : rxb[7-i];
      repeat (6) @(negedge clk);
      cap = {cap[6:0], sdo};
      sclk_in = ~cpol;
      repeat (6) @(negedge clk);
      sclk_in = cpol;
    end
    repeat (8) @(negedge clk);
    chk(sclk_oe == 1'b0, "R8 slave leaves clock undriven", sclk_oe, 0);
    rd(RA_DATA, v);
    if (expect_run) begin
      chk(irq == 1'b1, "R8 slave completion", irq, 1);
      chk(v == rxb, "R8 slave received byte", v, rxb);
      chk(cap == (lsb ? rev8(tx) : tx), "R8 slave transmitted byte", cap, lsb ? rev8(tx) : tx);
      chk(sdo_oe == 1'b1, "R8 slave drives output when selected", sdo_oe, 1);
    end else begin
      chk(irq == 1'b0, "R8 deselected slave ignores clock", irq, 0);
      chk(v == tx, "R8 deselected buffer untouched", v, tx);
      chk(sdo_oe == 1'b0, "R8 deselected output released", sdo_oe, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(RA_CTRL, v); chk(v == 8'h00, "R1 control reset", v, 0);
    rd(RA_STAT, v); chk(v == 8'h00, "R1 status reset", v, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk({sclk_oe, sdo_oe, sel_n_oe} == 3'b000, "R1 enables reset", {sclk_oe, sdo_oe, sel_n_oe}, 0);
    chk(sel_n_out == 1'b1, "R1 select high", sel_n_out, 1);

    // R10 control readback
    wr(RA_CTRL, 8'h3B);
    rd(RA_CTRL, v); chk(v == 8'h3B, "R10 control readback", v, 8'h3B);
    wr(RA_CTRL, 8'h00);

    // R2 R4 exhaustive byte sweep, fast rate, MSB first
    for (int b = 0; b < 256; b++)
      master_xfer(2'd0, 1'b0, 1'b0, 8'(b), 8'(b) ^ 8'h5A, 1'b0, 1'b1);
    wr(RA_STAT, 8'h00);
    chk(irq == 1'b0, "R6 flag cleared by writing zero", irq, 0);

    // R3 R4 every rate, order and polarity
    for (int m = 0; m < 3; m++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 2; c++) begin
          master_xfer(2'(m), l[0], c[0], 8'hC1, 8'h3E, 1'b0, 1'b1);
          wr(RA_STAT, 8'h00);
        end

    // R7 collision with check enabled
    master_xfer(2'd1, 1'b0, 1'b0, 8'h96, 8'h69, 1'b1, 1'b1);
    rd(RA_STAT, v); chk(v == 8'h03, "R7 collision flag set", v, 8'h03);
    wr(RA_STAT, 8'h01);
    rd(RA_STAT, v); chk(v == 8'h01, "R6 writing one keeps flag", v, 8'h01);
    wr(RA_STAT, 8'h00);
    rd(RA_STAT, v); chk(v == 8'h00, "R7 collision flag cleared", v, 0);
    // R7 collision with check disabled
    master_xfer(2'd1, 1'b1, 1'b1, 8'h4D, 8'hB2, 1'b1, 1'b0);
    rd(RA_STAT, v); chk(v == 8'h01, "R7 no collision flag when check off", v, 8'h01);
    wr(RA_STAT, 8'h00);
    col_chk_en = 1'b1;

    // R9 R10 disable mid-transfer
    s_mode = 1'b0;
    wr(RA_CTRL, 8'h25);
    wr(RA_DATA, 8'h11);
    repeat (20) @(negedge clk);
    rd(RA_STAT, v); chk(v == 8'h04, "R10 busy bit during transfer", v, 8'h04);
    wr(RA_CTRL, 8'h24);
    chk({sclk_oe, sdo_oe, sel_n_oe} == 3'b000, "R9 enables drop", {sclk_oe, sdo_oe, sel_n_oe}, 0);
    @(negedge clk);
    chk(sel_n_out == 1'b1, "R9 select released on disable", sel_n_out, 1);
    repeat (300) @(negedge clk);
    chk(irq == 1'b0, "R9 no completion after disable", irq, 0);
    rd(RA_STAT, v); chk(v == 8'h00, "R9 idle after disable", v, 0);

    // R5 select enable off in master mode
    wr(RA_CTRL, 8'h01);
    chk(sel_n_oe == 1'b0, "R5 select not driven when disabled", sel_n_oe, 0);
    chk(sclk_oe == 1'b1, "R2 clock driven in master mode", sclk_oe, 1);

    // R8 slave runs
    slave_xfer(1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b1);
    slave_xfer(1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 8'h6E, 1'b1);
    slave_xfer(1'b0, 1'b0, 1'b1, 1'b1, 8'h5B, 8'hC4, 1'b0);
    slave_xfer(1'b0, 1'b1, 1'b0, 1'b1, 8'h17, 8'hE8, 1'b1);

    finish_run();
  end
endmodule